// File: doc/BRIEF.md
# Priority-Based Reference Qualifier and Selector

This block watches twelve timing references. Each reference arrives with an activity-alarm flag and a frequency-offset in-range flag, which an upstream monitor produces. A reference counts as "good" while its alarm is low and its offset flag is high. A good reference must stay good for a programmable number of whole seconds before it is qualified. Time is counted by a one-cycle seconds tick supplied from outside. A qualified reference loses its qualification on the cycle after it stops being good. Every reference has its own timer.

From the qualified references that have a nonzero priority, the block chooses one as the active reference. Each reference has a 4-bit priority, and a lower value is preferred. While the present choice stays eligible, it keeps its place against any reference of equal priority. Single-cycle events flag a qualification, a disqualification and a change of the active reference. A system controller uses these events to interrupt software or to steer a clock-recovery loop.

Top module: `ref_qual_select`

## Requirements
- R1: While reset is high and in the first cycle after it, `qual_mask` is 0, `sel_idx` is 0 and all three events are low.
- R2: A reference that stays good (alarm low, offset flag high) is qualified on the edge that takes the (Q+1)-th seconds tick since it became good, where Q is `qual_time` (0 to 63). `qual_mask` bit n-1 belongs to reference n.
- R3: If a reference stops being good before it qualifies, its count of ticks restarts from zero.
- R4: A qualified reference whose alarm rises, or whose offset flag falls, clears its `qual_mask` bit on the next clock edge.
- R5: `qual_evt` pulses for one cycle, in the same cycle that any `qual_mask` bit rises. `disq_evt` pulses for one cycle, in the same cycle that any bit falls.
- R6: The priority of reference n is `prio[4n-1:4n-4]`. In each byte, the odd reference therefore sits in the low nibble and the even reference in the high nibble. A lower value wins. A value of 0 excludes the reference from selection but leaves its `qual_mask` bit unaffected.
- R7: When eligible references have equal best priority, the one with the lowest number is selected.
- R8: While the current selection is still qualified and enabled, it is replaced only by a reference of strictly lower priority value.
- R9: `sel_idx` follows `qual_mask` and `prio` one edge later. It holds 1 to 12 for a selected reference and 0 when none is eligible. `sel_evt` pulses for one cycle in the cycle that `sel_idx` changes.
- R10: Without a seconds tick, no `qual_mask` bit rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| act_alarm | input | 12 | Activity alarm per reference, bit n-1 for reference n |
| offs_ok | input | 12 | Offset within qualification range per reference |
| prio | input | 48 | Packed 4-bit priorities, reference n in bits 4n-1..4n-4 |
| qual_time | input | 6 | Qualification time in seconds |
| qual_mask | output | 12 | Qualified references |
| sel_idx | output | 4 | Selected reference number, 0 for none |
| qual_evt | output | 1 | A reference became qualified |
| disq_evt | output | 1 | A reference was disqualified |
| sel_evt | output | 1 | The selected reference changed |

## Verification
A timer stuck or off by one shows at the ports as a `qual_mask` bit that rises one tick early or one tick late. It becomes visible on the tick edge where qualification is due. A broken selection scan or a broken hold rule shows as a wrong `sel_idx` one edge after the mask or priority change that caused it. The bench therefore checks the mask on exact tick boundaries. It checks the selection one edge after every stimulus. It sweeps the winning priority across all twelve positions.

// File: rtl/rqs_pkg.sv
package rqs_pkg;
  localparam int unsigned PRIO_W = 4;
  typedef logic [PRIO_W-1:0] prio_t;

  function automatic logic prio_better(input prio_t a, input prio_t b);
    return a < b;
  endfunction
endpackage

// File: rtl/rqs_qual_timer.sv
module rqs_qual_timer #(
  parameter int QT_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            good,
  input  logic [QT_W-1:0] qual_time,
  output logic            qualified,
  output logic            rise,
  output logic            fall
);
  localparam int CNT_W = QT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      qualified <= 1'b0;
      rise      <= 1'b0;
      fall      <= 1'b0;
    end else begin
      rise <= 1'b0;
      fall <= 1'b0;
      if (!good) begin
        cnt       <= '0;
        qualified <= 1'b0;
        fall      <= qualified;
      end else if (tick && !qualified) begin
        cnt <= cnt_inc;
        if (cnt_inc > {1'b0, qual_time}) begin
          qualified <= 1'b1;
          rise      <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rqs_prio_pick.sv
module rqs_prio_pick
  import rqs_pkg::*;
#(
  parameter int N    = 12,
  parameter int SEL_W = 4
) (
  input  logic [N-1:0] elig,
  input  prio_t        prio_arr [N],
  output logic [SEL_W-1:0] best_idx,
  output prio_t            best_prio
);
  always_comb begin
    best_idx  = '0;
    best_prio = '1;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (best_idx == '0 || prio_better(prio_arr[i], best_prio))) begin
        best_idx  = SEL_W'(i + 1);
        best_prio = prio_arr[i];
      end
    end
  end
endmodule

// File: rtl/ref_qual_select.sv
module ref_qual_select
  import rqs_pkg::*;
#(
  parameter int NUM_REFS = 12,
  parameter int QT_W     = 6,
  localparam int SEL_W   = $clog2(NUM_REFS + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sec_tick,
  input  logic [NUM_REFS-1:0]        act_alarm,
  input  logic [NUM_REFS-1:0]        offs_ok,
  input  logic [NUM_REFS*PRIO_W-1:0] prio,
  input  logic [QT_W-1:0]            qual_time,
  output logic [NUM_REFS-1:0]        qual_mask,
  output logic [SEL_W-1:0]           sel_idx,
  output logic                       qual_evt,
  output logic                       disq_evt,
  output logic                       sel_evt
);
  prio_t               prio_arr [NUM_REFS];
  logic [NUM_REFS-1:0] enabled;
  logic [NUM_REFS-1:0] elig;
  logic [NUM_REFS-1:0] rise_v;
  logic [NUM_REFS-1:0] fall_v;

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref
    assign prio_arr[g] = prio[g*PRIO_W +: PRIO_W];
    assign enabled[g]  = prio_arr[g] != '0;

    rqs_qual_timer #(.QT_W(QT_W)) u_tmr (
      .clk       (clk),
      .rst       (rst),
      .tick      (sec_tick),
      .good      (!act_alarm[g] && offs_ok[g]),
      .qual_time (qual_time),
      .qualified (qual_mask[g]),
      .rise      (rise_v[g]),
      .fall      (fall_v[g])
    );
  end

  assign elig     = qual_mask & enabled;
  assign qual_evt = |rise_v;
  assign disq_evt = |fall_v;

  logic [SEL_W-1:0] best_idx;
  prio_t            best_prio;

  rqs_prio_pick #(.N(NUM_REFS), .SEL_W(SEL_W)) u_pick (
    .elig      (elig),
    .prio_arr  (prio_arr),
    .best_idx  (best_idx),
    .best_prio (best_prio)
  );

  logic             cur_ok;
  prio_t            cur_prio;
  logic [SEL_W-1:0] sel_next;

  always_comb begin
    cur_ok   = 1'b0;
    cur_prio = '1;
    for (int i = 0; i < NUM_REFS; i++) begin
      if (sel_idx == SEL_W'(i + 1)) begin
        cur_ok   = elig[i];
        cur_prio = prio_arr[i];
      end
    end
    if (cur_ok) begin
      sel_next = (best_idx != '0 && prio_better(best_prio, cur_prio)) ? best_idx : sel_idx;
    end else begin
      sel_next = best_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_idx <= '0;
      sel_evt <= 1'b0;
    end else begin
      sel_idx <= sel_next;
      sel_evt <= sel_next != sel_idx;
    end
  end
endmodule

// File: rtl/rqs_checker.sv
module rqs_checker #(
  parameter int N     = 12,
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sec_tick,
  input logic [N-1:0]     act_alarm,
  input logic [N-1:0]     offs_ok,
  input logic [N-1:0]     qual_mask,
  input logic [SEL_W-1:0] sel_idx,
  input logic             qual_evt,
  input logic             disq_evt,
  input logic             sel_evt
);
  logic [N-1:0] mask_d;
  always_ff @(posedge clk) begin
    if (rst) mask_d <= '0;
    else     mask_d <= qual_mask;
  end

  assert_alarm_disq_R4: assert property (@(posedge clk) disable iff (rst)
    (act_alarm != '0) |=> ((qual_mask & $past(act_alarm)) == '0));

  assert_offset_disq_R4: assert property (@(posedge clk) disable iff (rst)
    (offs_ok != '1) |=> ((qual_mask & ~$past(offs_ok)) == '0));

  assert_qual_evt_R5: assert property (@(posedge clk) disable iff (rst)
    qual_evt |-> ((qual_mask & ~$past(qual_mask)) != '0));

  assert_disq_evt_R5: assert property (@(posedge clk) disable iff (rst)
    disq_evt |-> (($past(qual_mask) & ~qual_mask) != '0));

  assert_no_tick_no_rise_R10: assert property (@(posedge clk) disable iff (rst)
    !sec_tick |=> ((qual_mask & ~$past(qual_mask)) == '0));

  assert_sel_qualified_R9: assert property (@(posedge clk) disable iff (rst)
    (sel_idx != '0) |-> mask_d[sel_idx - SEL_W'(1)]);

  assert_sel_evt_R9: assert property (@(posedge clk) disable iff (rst)
    sel_evt |-> (sel_idx != $past(sel_idx)));
endmodule

bind ref_qual_select rqs_checker #(.N(NUM_REFS), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sec_tick  (sec_tick),
  .act_alarm (act_alarm),
  .offs_ok   (offs_ok),
  .qual_mask (qual_mask),
  .sel_idx   (sel_idx),
  .qual_evt  (qual_evt),
  .disq_evt  (disq_evt),
  .sel_evt   (sel_evt)
);

// File: tb/ref_qual_select_tb.sv
module ref_qual_select_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sec_tick = 1'b0;
  logic [N-1:0]  act_alarm = '1;
  logic [N-1:0]  offs_ok = '0;
  logic [N*4-1:0] prio = '0;
  logic [5:0]    qual_time = 6'd2;
  logic [N-1:0]  qual_mask;
  logic [3:0]    sel_idx;
  logic          qual_evt, disq_evt, sel_evt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ref_qual_select u_dut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .act_alarm(act_alarm),
    .offs_ok(offs_ok), .prio(prio), .qual_time(qual_time),
    .qual_mask(qual_mask), .sel_idx(sel_idx), .qual_evt(qual_evt),
    .disq_evt(disq_evt), .sel_evt(sel_evt)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick();
    sec_tick = 1'b1;
    step();
    sec_tick = 1'b0;
  endtask

  task automatic set_all_prio(input logic [3:0] v);
    for (int i = 0; i < N; i++) prio[4*i +: 4] = v;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(); step();
    // R1: reset state
    chk("R1 mask in reset", qual_mask, 0);
    chk("R1 sel in reset", sel_idx, 0);
    rst = 1'b0;
    step();
    chk("R1 mask after reset", qual_mask, 0);
    chk("R1 events after reset", {qual_evt, disq_evt, sel_evt}, 0);

    // R10: good but no ticks
    act_alarm = '0; offs_ok = '1; set_all_prio(4'd8);
    repeat (5) step();
    chk("R10 no tick no qualify", qual_mask, 0);

    // R2: qual_time=2 -> third tick qualifies
    tick(); tick();
    chk("R2 not yet at tick 2", qual_mask, 0);
    tick();
    chk("R2 qualified at tick 3", qual_mask, 12'hFFF);
    chk("R5 qual_evt pulse", qual_evt, 1);
    step();
    chk("R5 qual_evt one cycle", qual_evt, 0);
    chk("R7 tie picks lowest", sel_idx, 1);
    chk("R9 sel_evt on change", sel_evt, 1);

    // R6 sweep: nibble position decides the winner
    for (int r = 0; r < N; r++) begin
      set_all_prio(4'd8);
      prio[4*r +: 4] = 4'd1;
      step();
      chk($sformatf("R6 sweep winner ref %0d", r + 1), sel_idx, r + 1);
      if (r > 0) chk("R9 sel_evt in sweep", sel_evt, 1);
      step();
    end

    // R8: equal priority does not displace current selection
    set_all_prio(4'd8);
    step();
    chk("R8 hold on tie", sel_idx, 12);
    chk("R8 no sel_evt", sel_evt, 0);

    // R4: alarm disqualifies next edge
    act_alarm[11] = 1'b1;
    step();
    chk("R4 alarm clears bit", qual_mask, 12'h7FF);
    chk("R5 disq_evt pulse", disq_evt, 1);
    step();
    chk("R9 reselect after alarm", sel_idx, 1);
    chk("R5 disq_evt one cycle", disq_evt, 0);

    // R4: offset leaves range
    offs_ok[0] = 1'b0;
    step();
    chk("R4 offset clears bit", qual_mask, 12'h7FE);
    step();
    chk("R9 reselect after offset", sel_idx, 2);

    // R6: priority zero disables but leaves mask
    prio[7:4] = 4'd0;
    step();
    chk("R6 prio zero skipped", sel_idx, 3);
    chk("R6 mask unaffected", qual_mask, 12'h7FE);

    // R3: timer restart
    offs_ok[0] = 1'b1;
    tick(); tick();
    offs_ok[0] = 1'b0;
    step();
    offs_ok[0] = 1'b1;
    tick(); tick();
    chk("R3 restarted not qualified", qual_mask[0], 0);
    tick();
    chk("R3 qualified after full time", qual_mask[0], 1);
    step();
    chk("R8 hold vs new equal", sel_idx, 3);

    // R2: qual_time 0 qualifies on first tick
    qual_time = 6'd0;
    act_alarm[11] = 1'b0;
    step();
    chk("R2 qt0 needs tick", qual_mask[11], 0);
    tick();
    chk("R2 qt0 one tick", qual_mask[11], 1);

    // R8: strictly better replaces
    prio[47:44] = 4'd7;
    step();
    chk("R8 strictly better wins", sel_idx, 12);

    // R9: none eligible
    act_alarm = '1;
    step();
    chk("R4 all cleared", qual_mask, 0);
    step();
    chk("R9 none selected", sel_idx, 0);
    chk("R9 sel_evt to none", sel_evt, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule